// File: doc/BRIEF.md
# DDR Refresh Scheduler with Deferral Budget

This block decides when a DDR SDRAM controller must issue an auto-refresh. A free-running counter produces one interval tick every `TICK_CYCLES` controller clocks, so the average spacing of refreshes matches the memory's retention schedule. Each tick adds one owed refresh to a debt counter. Each refresh that the command arbiter accepts removes one.

While the arbiter has other work, refreshes can wait. The block offers a normal request only when the arbiter reports that it is idle. The debt is capped at `MAX_DEBT`. Once that cap is reached, the request turns urgent and is raised whether or not the arbiter is idle. The cap keeps the longest gap between two refreshes inside the device limit.

After the arbiter accepts a refresh, the block holds clock enable high and raises a busy flag for `TRFC_CYCLES` clocks. During that window it offers no new request. The arbiter uses the busy flag to hold back its own commands.

Top module: `refresh_sched`

## Requirements
- R1: After reset is released, the first interval tick happens in the `TICK_CYCLES`-th cycle (cycle index `TICK_CYCLES-1`, counting from 0). From then on there is one tick every `TICK_CYCLES` cycles. Each tick adds one to the debt.
- R2: A normal request (`ref_req_o`=1, `ref_urgent_o`=0) is raised only when all of these hold: the debt is between 1 and `MAX_DEBT-1`, `arb_idle_i` is 1, and `busy_o` is 0.
- R3: When the debt equals `MAX_DEBT`, `ref_urgent_o` is 1. While `busy_o` is 0, `ref_req_o` is then 1 whatever the value of `arb_idle_i`.
- R4: The debt never goes above `MAX_DEBT`. A tick that arrives while the debt is at the cap is dropped.
- R5: A grant is accepted in any cycle where `ref_req_o` and `ref_gnt_i` are both 1. An accepted grant lowers the debt by one. If a tick and an accepted grant fall in the same cycle, the debt does not change.
- R6: After an accepted grant, `busy_o` is 1 for exactly `TRFC_CYCLES` cycles, starting in the next cycle. No request is raised while `busy_o` is 1.
- R7: `cke_hold_o` is 1 in the cycle of an accepted grant and in every cycle where `busy_o` is 1. In all other cycles it is 0.
- R8: A synchronous active-high `rst` clears the debt, the tick counter and the busy timer. Right after reset, all outputs are 0.
- R9: `ref_gnt_i` has no effect in a cycle where `ref_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_idle_i | input | 1 | Arbiter has no other command pending |
| ref_gnt_i | input | 1 | Arbiter issues the refresh this cycle |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Debt is at its cap |
| cke_hold_o | output | 1 | Clock enable must be held high |
| busy_o | output | 1 | Refresh cycle time in progress; no commands allowed |

## Verification
The hardest state to reach from the ports is a debt at the cap with further ticks arriving. Reaching it takes `MAX_DEBT` full intervals with the arbiter never idle and no grant given. The stimulus holds `arb_idle_i` low and withholds grants for several intervals beyond the cap. It then gives a single grant right after a known tick, so a dropped tick shows up as the request falling back from urgent to quiet. Long random segments use a varying idle probability, so they also reach the cap and let ticks and grants coincide. A cycle model in the bench checks every output in every one of those cycles.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
    // Request class offered to the command arbiter
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_NORMAL = 2'd1,
        REQ_URGENT = 2'd2
    } req_kind_e;

    // Defaults for a 6 ns clock: 7.8 us interval, 120 ns refresh cycle
    localparam int unsigned DEF_TICK_CYCLES = 1300;
    localparam int unsigned DEF_TRFC_CYCLES = 20;
    localparam int unsigned DEF_MAX_DEBT    = 8;
endpackage

// File: rtl/refsch_tick.sv
// Interval tick generator: one pulse every TICK_CYCLES clocks.
module refsch_tick #(
    parameter int unsigned TICK_CYCLES = 1300
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(TICK_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = (s_q.cnt == CW'(TICK_CYCLES - 1));
        if (tick_o) s_d.cnt = '0;
        else        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/refsch_debt.sv
// Counts owed refreshes, saturating at MAX_DEBT.
module refsch_debt #(
    parameter int unsigned MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic take_i,
    output logic owed_o,
    output logic full_o
);
    localparam int unsigned DW = $clog2(MAX_DEBT + 1);

    typedef struct packed {
        logic [DW-1:0] debt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        full_o = (s_q.debt == DW'(MAX_DEBT));
        owed_o = (s_q.debt != '0);
        if (tick_i && !take_i) begin
            if (!full_o) s_d.debt = s_q.debt + 1'b1;
        end else if (take_i && !tick_i) begin
            s_d.debt = s_q.debt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/refsch_trfc.sv
// Refresh cycle-time window: busy for TRFC_CYCLES after a load.
module refsch_trfc #(
    parameter int unsigned TRFC_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int unsigned TW = $clog2(TRFC_CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0] left;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        busy_o = (s_q.left != '0);
        if (load_i)      s_d.left = TW'(TRFC_CYCLES);
        else if (busy_o) s_d.left = s_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = DEF_TICK_CYCLES,
    parameter int unsigned TRFC_CYCLES = DEF_TRFC_CYCLES,
    parameter int unsigned MAX_DEBT    = DEF_MAX_DEBT
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_idle_i,
    input  logic ref_gnt_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic cke_hold_o,
    output logic busy_o
);
    logic      tick;
    logic      owed;
    logic      full;
    logic      take;
    req_kind_e kind;

    refsch_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    refsch_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .take_i (take),
        .owed_o (owed),
        .full_o (full)
    );

    refsch_trfc #(.TRFC_CYCLES(TRFC_CYCLES)) u_trfc (
        .clk    (clk),
        .rst    (rst),
        .load_i (take),
        .busy_o (busy_o)
    );

    always_comb begin
        kind = REQ_NONE;
        if (owed && !busy_o) begin
            if (full)            kind = REQ_URGENT;
            else if (arb_idle_i) kind = REQ_NORMAL;
        end
        ref_req_o    = (kind != REQ_NONE);
        ref_urgent_o = full;
        take         = ref_req_o && ref_gnt_i;
        cke_hold_o   = busy_o || take;
    end
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
    parameter int unsigned TRFC_CYCLES = 20
) (
    input logic clk,
    input logic rst,
    input logic arb_idle_i,
    input logic ref_gnt_i,
    input logic ref_req_o,
    input logic ref_urgent_o,
    input logic cke_hold_o,
    input logic busy_o
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_q <= 0;
        else                run_q <= run_q + 1;
    end

    p_normal_needs_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && !ref_urgent_o) |-> arb_idle_i);

    p_urgent_forces_req_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_urgent_o && !busy_o) |-> ref_req_o);

    p_busy_blocks_req_r6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ref_req_o);

    p_grant_starts_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && ref_gnt_i) |=> busy_o);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < TRFC_CYCLES));

    p_busy_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && run_q == TRFC_CYCLES - 1) |=> !busy_o);

    p_cke_on_grant_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && ref_gnt_i) |-> cke_hold_o);

    p_cke_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> cke_hold_o);
endmodule

bind refresh_sched refsch_chk #(.TRFC_CYCLES(TRFC_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .arb_idle_i   (arb_idle_i),
    .ref_gnt_i    (ref_gnt_i),
    .ref_req_o    (ref_req_o),
    .ref_urgent_o (ref_urgent_o),
    .cke_hold_o   (cke_hold_o),
    .busy_o       (busy_o)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int TB_TICK = 40;
    localparam int TB_TRFC = 5;
    localparam int TB_MAX  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arb_idle_i = 1'b0;
    logic ref_gnt_i = 1'b0;
    logic ref_req_o, ref_urgent_o, cke_hold_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state
    int m_debt = 0;
    int m_tick = 0;
    int m_left = 0;

    always #2.5 clk = ~clk;

    refresh_sched #(
        .TICK_CYCLES(TB_TICK),
        .TRFC_CYCLES(TB_TRFC),
        .MAX_DEBT   (TB_MAX)
    ) u_refresh_sched (
        .clk          (clk),
        .rst          (rst),
        .arb_idle_i   (arb_idle_i),
        .ref_gnt_i    (ref_gnt_i),
        .ref_req_o    (ref_req_o),
        .ref_urgent_o (ref_urgent_o),
        .cke_hold_o   (cke_hold_o),
        .busy_o       (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_req(input bit idle);
        return (m_debt != 0) && (m_left == 0) && ((m_debt == TB_MAX) || idle);
    endfunction

    // one cycle, entered and left at a falling edge
    task automatic cycle(input bit r, input bit idle, input bit gnt);
        bit er, acc, tk;
        rst = r; arb_idle_i = idle; ref_gnt_i = gnt;
        #1;
        er = exp_req(idle);
        if (!r) begin
            check(ref_req_o == er, "R2 ref_req_o", ref_req_o, er);
            check(ref_urgent_o == (m_debt == TB_MAX), "R3 ref_urgent_o", ref_urgent_o, m_debt == TB_MAX);
            check(busy_o == (m_left != 0), "R6 busy_o", busy_o, m_left != 0);
            check(cke_hold_o == ((m_left != 0) || (er && gnt)), "R7 cke_hold_o",
                  cke_hold_o, (m_left != 0) || (er && gnt));
        end
        @(posedge clk);
        if (r) begin
            m_debt = 0; m_tick = 0; m_left = 0;
        end else begin
            tk  = (m_tick == TB_TICK - 1);
            acc = er && gnt;          // R9: grant without request ignored
            m_tick = tk ? 0 : m_tick + 1;
            m_debt = m_debt + int'(tk) - int'(acc);
            if (m_debt > TB_MAX) m_debt = TB_MAX;   // R4 cap
            m_left = acc ? TB_TRFC : ((m_left != 0) ? m_left - 1 : 0);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int first;
        int pidle;
        int pgnt;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        repeat (3) cycle(1'b1, 1'b1, 1'b1);
        // R8: reset state
        check(ref_req_o == 0 && busy_o == 0 && cke_hold_o == 0 && ref_urgent_o == 0,
              "R8 outputs after reset", {ref_req_o, busy_o, cke_hold_o, ref_urgent_o}, 0);

        // R1 and R9: grant pulled with no request; first request at cycle TB_TICK
        first = -1;
        for (int i = 0; i < TB_TICK + 3; i++) begin
            if (first < 0 && ref_req_o) first = i;
            if (i < TB_TICK) check(busy_o == 0, "R9 grant without request", busy_o, 0);
            cycle(1'b0, 1'b1, (i < TB_TICK) ? 1'b1 : 1'b0);
        end
        check(first == TB_TICK, "R1 first tick position", first, TB_TICK);

        // R4/R3: starve past the cap
        for (int i = 0; i < (TB_MAX + 3) * TB_TICK; i++) cycle(1'b0, 1'b0, 1'b0);
        check(ref_urgent_o == 1, "R3 urgent at cap", ref_urgent_o, 1);
        check(ref_req_o == 1, "R3 request with arbiter busy", ref_req_o, 1);
        while (m_tick != 1) cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < TB_TRFC; i++) cycle(1'b0, 1'b0, 1'b0);
        check(ref_urgent_o == 0, "R4 debt capped, one grant leaves it below cap", ref_urgent_o, 0);
        check(ref_req_o == 0, "R4 no request while below cap and not idle", ref_req_o, 0);

        // R5: drain with grants, including coinciding ticks
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'b1, 1'b1);
        check(ref_urgent_o == 0, "R5 drained", ref_urgent_o, 0);

        // random segments with varying idle and grant probabilities
        for (int seg = 0; seg < 40; seg++) begin
            pidle = int'($urandom_range(0, 100));
            pgnt  = int'($urandom_range(10, 100));
            for (int i = 0; i < 600; i++)
                cycle(($urandom_range(0, 4999) == 0),
                      (int'($urandom_range(0, 99)) < pidle),
                      (int'($urandom_range(0, 99)) < pgnt));
        end

        // R8: reset mid-run clears debt
        for (int i = 0; i < 3 * TB_TICK; i++) cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 1'b0);
        check(ref_req_o == 0 && busy_o == 0, "R8 mid-run reset", {ref_req_o, busy_o}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule